// File: doc/BRIEF.md
# Serial Flash Operation Phase Sequencer

This block runs one serial-flash style operation as a master on a half-duplex bus of up to four data lanes. An operation is a chain of phases: opcode bytes, then a group of address and dummy bytes counted together, then an optional data phase that either sends or receives bytes. The configuration (phase byte counts, lane mode, a cross-mode bit, a no-data bit, the data direction and the data byte count) is latched on a one-cycle `start` pulse.

Every byte sent on the bus, whether opcode, address, dummy or outbound data, arrives on one valid/ready byte stream in bus order. Inbound data bytes leave on a second valid/ready stream with a one-byte holding register. The bus clock waits instead of running ahead: if the outbound stream has no byte when one is due, or the inbound holding register is still full when a new read byte would begin, the sequencer holds SCK low and chip select asserted until it can go on. `tx_ready` never depends on `tx_valid`. `rx_data` holds steady while `rx_valid` is high and `rx_ready` is low.

The bus runs in SPI mode 0: SCK idles low, the master changes its outputs after each falling edge, and it samples inbound lanes while SCK is high, before the falling edge. Each SCK period spans two core clock cycles.

Top module: `qspi_phase_seq`

## Requirements
- R1: After reset `cs_n`=1, `sck`=0, `io_oe`=0, `done`=0, `tx_ready`=0 and `rx_valid`=0.
- R2: The opcode phase sends `cfg_cmd_len` stream bytes, always on a single lane: IO0 only, `io_oe`=4'b0001, MSB first, 8 SCK periods per byte.
- R3: The address/dummy phase sends the next `cfg_ad_len` stream bytes, 0 to 15 of them. With `cfg_xmode`=1 they go on a single lane (IO0). With `cfg_xmode`=0 they use the configured lane count.
- R4: `cfg_lane_mode` gives the lane count: 0 means 1 lane, 1 means 2 lanes, and 2 or 3 mean 4 lanes. A byte takes 8, 4 or 2 SCK periods. In 2-lane mode, bits [7:6] go first on IO1:IO0 with IO1 the more significant bit. In 4-lane mode, bits [7:4] go first on IO3:IO0. `io_oe` is 4'b0011 or 4'b1111.
- R5: With `cfg_read`=0, the data phase sends `cfg_data_len` stream bytes on the configured lane count.
- R6: With `cfg_read`=1, `io_oe` is 0 from the first data SCK period onward. Each byte is assembled MSB first from IO1 (1 lane), from IO1:IO0 (2 lanes) or from IO3:IO0 (4 lanes), and is delivered on `rx_data`/`rx_valid`.
- R7: If `cfg_nodata`=1 or `cfg_data_len`=0, the operation ends after the address/dummy phase. No further SCK periods run and no further stream bytes are taken.
- R8: While `tx_ready`=1 and `tx_valid`=0, SCK stays low. While the inbound holding register is full, no read SCK period runs. `rx_data` is stable while `rx_valid`=1 and `rx_ready`=0.
- R9: `done` is a one-cycle pulse after the final byte, with `cs_n` still low. In the next cycle `cs_n`=1 and `busy`=0.
- R10: `cs_n` goes low the cycle after `start` and stays low until after `done`. While `cs_n`=1, `sck`=0 and `io_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that latches the configuration and begins an operation while idle |
| cfg_cmd_len | input | 4 | Opcode byte count (normally 1) |
| cfg_ad_len | input | 4 | Address plus dummy byte count |
| cfg_lane_mode | input | 2 | Lane count code: 0 single, 1 dual, 2 or 3 quad |
| cfg_xmode | input | 1 | Keep the address and dummy phases on one lane |
| cfg_nodata | input | 1 | Skip the data phase |
| cfg_read | input | 1 | Data phase direction: 1 inbound, 0 outbound |
| cfg_data_len | input | LEN_W | Data byte count |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| tx_valid | input | 1 | Outbound byte available |
| tx_ready | output | 1 | Sequencer accepts the outbound byte |
| tx_data | input | 8 | Outbound byte (opcode, address, dummy or data) |
| rx_valid | output | 1 | Inbound byte available |
| rx_ready | input | 1 | Consumer accepts the inbound byte |
| rx_data | output | 8 | Inbound byte |
| sck | output | 1 | Bus clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
The bench covers these corner cases:

- **Cross-mode with a multi-lane data phase.** A design that ignores the cross-mode bit sends address bytes on 2 or 4 lanes, so the bench sees the wrong lane pattern and the wrong period count.
- **Lane mode 3, and the single-lane read taken from IO1.** Decoding mode 3 wrongly, or sampling IO0, corrupts every inbound byte.
- **Empty data phase.** The bench runs the no-data bit with a nonzero count, and a zero count with the bit clear. A design that honours only one of these either waits forever for stream bytes or runs extra clocks.
- **Stalls on both streams.** The bench starves the outbound stream and holds `rx_ready` low for several cycles. A sequencer that clocks on regardless loses or overwrites bytes and shows SCK edges during the stall.

// File: rtl/qspi_seq_pkg.sv
package qspi_seq_pkg;

  typedef enum logic [1:0] {PH_CMD = 2'd0, PH_AD = 2'd1, PH_DATA = 2'd2} phase_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0, ST_LOAD = 3'd1, ST_LO = 3'd2, ST_HI = 3'd3, ST_FIN = 3'd4
  } state_e;

  typedef enum logic [1:0] {LW_1 = 2'd0, LW_2 = 2'd1, LW_4 = 2'd2} lanew_e;

  typedef struct packed {
    logic [3:0] cmd_len;
    logic [3:0] ad_len;
    lanew_e     lanes;
    logic       xmode;
    logic       nodata;
    logic       rd;
  } cfg_t;

  function automatic lanew_e lanes_of(input logic [1:0] mode);
    case (mode)
      2'd0:    return LW_1;
      2'd1:    return LW_2;
      default: return LW_4;
    endcase
  endfunction

  // index of the last SCK period of a byte for a lane width
  function automatic logic [2:0] last_slot(input lanew_e w);
    case (w)
      LW_1:    return 3'd7;
      LW_2:    return 3'd3;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/qspi_lane_shifter.sv
module qspi_lane_shifter
  import qspi_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] load_data_i,
  input  logic       shift_i,
  input  lanew_e     width_i,
  input  logic       drive_i,
  input  logic [3:0] io_in_i,
  output logic [3:0] io_out_o,
  output logic [3:0] io_oe_o,
  output logic [7:0] data_o
);
  logic [7:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= 8'h00;
    end else if (load_i) begin
      sh_q <= load_data_i;
    end else if (shift_i) begin
      case (width_i)
        LW_1:    sh_q <= {sh_q[6:0], io_in_i[1]};
        LW_2:    sh_q <= {sh_q[5:0], io_in_i[1:0]};
        default: sh_q <= {sh_q[3:0], io_in_i[3:0]};
      endcase
    end
  end

  logic [3:0] mask;
  always_comb begin
    case (width_i)
      LW_1: begin
        io_out_o = {3'b000, sh_q[7]};
        mask     = 4'b0001;
      end
      LW_2: begin
        io_out_o = {2'b00, sh_q[7:6]};
        mask     = 4'b0011;
      end
      default: begin
        io_out_o = sh_q[7:4];
        mask     = 4'b1111;
      end
    endcase
  end

  assign io_oe_o = drive_i ? mask : 4'b0000;
  assign data_o  = sh_q;
endmodule

// File: rtl/qspi_phase_ctrl.sv
module qspi_phase_ctrl
  import qspi_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  cfg_t             cfg_i,
  input  logic [LEN_W-1:0] data_len_i,
  input  logic             tx_valid_i,
  input  logic             rx_busy_i,
  output logic             tx_ready_o,
  output logic             load_o,
  output logic             shift_o,
  output lanew_e           width_o,
  output logic             drive_o,
  output logic             rx_cap_o,
  output logic             sck_o,
  output logic             cs_n_o,
  output logic             done_o,
  output logic             busy_o
);
  localparam int RW = (LEN_W > 4) ? LEN_W : 4;

  state_e           state;
  phase_e           phase;
  cfg_t             cfg_q;
  logic [LEN_W-1:0] dlen_q;
  logic [RW-1:0]    rem;
  logic [2:0]       slot;
  lanew_e           cur_w;
  logic             drive_q;

  logic   rd_data, go;
  lanew_e phase_w;

  assign rd_data    = (phase == PH_DATA) && cfg_q.rd;
  assign phase_w    = (phase == PH_CMD) ? LW_1 :
                      ((phase == PH_AD) && cfg_q.xmode) ? LW_1 : cfg_q.lanes;
  assign tx_ready_o = (state == ST_LOAD) && (rem != '0) && !rd_data;
  assign go         = (state == ST_LOAD) && (rem != '0) &&
                      (rd_data ? !rx_busy_i : tx_valid_i);
  assign load_o     = go && !rd_data;
  assign shift_o    = (state == ST_HI);
  assign rx_cap_o   = (state == ST_HI) && (slot == 3'd0) && rd_data;
  assign sck_o      = (state == ST_HI);
  assign cs_n_o     = (state == ST_IDLE);
  assign done_o     = (state == ST_FIN);
  assign busy_o     = (state != ST_IDLE);
  assign width_o    = cur_w;
  assign drive_o    = drive_q &&
                      ((state == ST_LOAD) || (state == ST_LO) || (state == ST_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      phase   <= PH_CMD;
      cfg_q   <= '0;
      dlen_q  <= '0;
      rem     <= '0;
      slot    <= 3'd0;
      cur_w   <= LW_1;
      drive_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_i) begin
          cfg_q   <= cfg_i;
          dlen_q  <= data_len_i;
          phase   <= PH_CMD;
          rem     <= RW'(cfg_i.cmd_len);
          cur_w   <= LW_1;
          drive_q <= 1'b1;
          state   <= ST_LOAD;
        end
        ST_LOAD: begin
          if (rem == '0) begin
            case (phase)
              PH_CMD: begin
                phase <= PH_AD;
                rem   <= RW'(cfg_q.ad_len);
              end
              PH_AD: begin
                phase <= PH_DATA;
                rem   <= cfg_q.nodata ? '0 : RW'(dlen_q);
              end
              default: state <= ST_FIN;
            endcase
          end else if (go) begin
            cur_w   <= phase_w;
            drive_q <= !rd_data;
            slot    <= last_slot(phase_w);
            state   <= ST_LO;
          end
        end
        ST_LO: state <= ST_HI;
        ST_HI: begin
          if (slot == 3'd0) begin
            rem   <= rem - RW'(1);
            state <= ST_LOAD;
          end else begin
            slot  <= slot - 3'd1;
            state <= ST_LO;
          end
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qspi_phase_seq.sv
module qspi_phase_seq
  import qspi_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       cfg_cmd_len,
  input  logic [3:0]       cfg_ad_len,
  input  logic [1:0]       cfg_lane_mode,
  input  logic             cfg_xmode,
  input  logic             cfg_nodata,
  input  logic             cfg_read,
  input  logic [LEN_W-1:0] cfg_data_len,
  output logic             busy,
  output logic             done,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  output logic             sck,
  output logic             cs_n,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_in
);
  cfg_t       cfg;
  logic       load, shift, drive, rx_cap, cap_d;
  lanew_e     width;
  logic [7:0] sh_data;

  assign cfg = '{cmd_len: cfg_cmd_len, ad_len: cfg_ad_len,
                 lanes: lanes_of(cfg_lane_mode), xmode: cfg_xmode,
                 nodata: cfg_nodata, rd: cfg_read};

  qspi_phase_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_i(cfg),
    .data_len_i(cfg_data_len), .tx_valid_i(tx_valid),
    .rx_busy_i(rx_valid || cap_d), .tx_ready_o(tx_ready), .load_o(load),
    .shift_o(shift), .width_o(width), .drive_o(drive), .rx_cap_o(rx_cap),
    .sck_o(sck), .cs_n_o(cs_n), .done_o(done), .busy_o(busy)
  );

  qspi_lane_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_data_i(tx_data),
    .shift_i(shift), .width_i(width), .drive_i(drive), .io_in_i(io_in),
    .io_out_o(io_out), .io_oe_o(io_oe), .data_o(sh_data)
  );

  // one-byte inbound holding register; capture one cycle after the last shift
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_d    <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= 8'h00;
    end else begin
      cap_d <= rx_cap;
      if (cap_d) begin
        rx_data  <= sh_data;
        rx_valid <= 1'b1;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/qspi_phase_seq_chk.sv
module qspi_phase_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic       cs_n,
  input logic       done,
  input logic       busy,
  input logic [3:0] io_oe,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data
);
  a_r9_done_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cs_n && busy));

  a_r9_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cs_n && !done && !busy));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> ((io_oe == 4'b0000) && !sck));

  a_r4_oe_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b0011) || (io_oe == 4'b1111));

  a_r8_tx_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> !sck);

  a_r8_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

bind qspi_phase_seq qspi_phase_seq_chk u_chk (.*);

// File: tb/test_qspi_phase_seq.sv
`timescale 1ns/1ps
module test_qspi_phase_seq;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0;
  logic [3:0] cfg_cmd_len = '0, cfg_ad_len = '0;
  logic [1:0] cfg_lane_mode = '0;
  logic cfg_xmode = 1'b0, cfg_nodata = 1'b0, cfg_read = 1'b0;
  logic [LEN_W-1:0] cfg_data_len = '0;
  logic busy, done, tx_ready, rx_valid, sck, cs_n;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic rx_ready = 1'b1;
  logic [7:0] rx_data;
  logic [3:0] io_out, io_oe;
  logic [3:0] io_in = 4'h0;

  qspi_phase_seq #(.LEN_W(LEN_W)) i_qspi_phase_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_cmd_len(cfg_cmd_len),
    .cfg_ad_len(cfg_ad_len), .cfg_lane_mode(cfg_lane_mode), .cfg_xmode(cfg_xmode),
    .cfg_nodata(cfg_nodata), .cfg_read(cfg_read), .cfg_data_len(cfg_data_len),
    .busy(busy), .done(done), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  typedef struct packed { logic [7:0] b; logic [2:0] w; logic [1:0] ph; } txe_t;

  txe_t       exp_tx[$];
  logic [7:0] exp_rx[$];
  logic [7:0] rd_src[$];
  int rd_w = 1, rd_bit = 0, sck_rises = 0;
  int nchk = 0, nfail = 0;
  bit rx_stall = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic string tagname(input logic [1:0] ph);
    case (ph)
      2'd0:    return "R2 opcode byte/width";
      2'd1:    return "R3 addr-dummy byte/width";
      default: return "R5 write data byte/width";
    endcase
  endfunction

  // slave model: present the next lane group after each SCK rise in a read phase (R6)
  logic [7:0] cur;
  always @(posedge sck) begin
    sck_rises++;
    if (!cs_n && io_oe == 4'b0000) begin
      #1;
      cur = (rd_src.size() != 0) ? rd_src[0] : 8'h00;
      case (rd_w)
        1:       io_in = {2'b00, cur[7-rd_bit], 1'b0};
        2:       io_in = {2'b00, cur[7-rd_bit], cur[6-rd_bit]};
        default: io_in = {cur[7-rd_bit], cur[6-rd_bit], cur[5-rd_bit], cur[4-rd_bit]};
      endcase
      rd_bit += rd_w;
      if (rd_bit >= 8) begin
        rd_bit = 0;
        if (rd_src.size() != 0) void'(rd_src.pop_front());
      end
    end
  end

  // outbound monitor (R2 R3 R4 R5)
  logic [7:0] mon_acc = 8'h00;
  int mon_n = 0, mon_w = 0, lw;
  txe_t e;
  always @(posedge sck) begin
    if (!cs_n && io_oe != 4'b0000) begin
      lw = (io_oe == 4'b0001) ? 1 : (io_oe == 4'b0011) ? 2 : 4;
      if (mon_n == 0) mon_w = lw;
      case (lw)
        1:       mon_acc = {mon_acc[6:0], io_out[0]};
        2:       mon_acc = {mon_acc[5:0], io_out[1:0]};
        default: mon_acc = {mon_acc[3:0], io_out};
      endcase
      mon_n += lw;
      if (mon_n >= 8) begin
        mon_n = 0;
        if (exp_tx.size() == 0) begin
          chk(1'b0, "R7 unexpected outbound byte", int'(mon_acc), 0);
        end else begin
          e = exp_tx.pop_front();
          chk(mon_acc == e.b && mon_w == int'(e.w), tagname(e.ph),
              int'(mon_acc) * 16 + mon_w, int'(e.b) * 16 + int'(e.w));
        end
      end
    end
  end

  // inbound consumer with optional stalls (R6 R8)
  int rx_cnt = 0, rx_snap = 0;
  bit rx_seen = 1'b0;
  logic [7:0] rx_exp;
  always @(posedge clk) begin
    #1;
    if (!rx_stall) rx_ready = 1'b1;
    else begin
      rx_cnt   = (rx_cnt + 1) % 6;
      rx_ready = (rx_cnt == 0);
    end
  end

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (!rx_seen) begin
        rx_seen = 1'b1;
        rx_snap = sck_rises;
      end
      if (rx_ready) begin
        rx_seen = 1'b0;
        if (exp_rx.size() == 0) chk(1'b0, "R6 unexpected inbound byte", int'(rx_data), 0);
        else begin
          rx_exp = exp_rx.pop_front();
          chk(rx_data == rx_exp, "R6 inbound byte", int'(rx_data), int'(rx_exp));
        end
        chk(sck_rises == rx_snap, "R8 no read clock while holding full", sck_rises, rx_snap);
      end
    end
  end

  task automatic run_op(input int ncmd, input int nad, input int lm, input bit xm,
                        input bit nd, input bit rd, input int ndat,
                        input logic [7:0] seed, input bit txst, input bit rxst);
    int lanes, hw, exp_rises, snap0, snap, t;
    logic [7:0] hdr[$];
    logic [7:0] v;
    lanes = (lm == 1) ? 2 : (lm >= 2) ? 4 : 1;
    hw = xm ? 1 : lanes;
    exp_rises = 0;
    for (int i = 0; i < ncmd; i++) begin
      v = seed + 8'(i);
      hdr.push_back(v); exp_tx.push_back('{v, 3'd1, 2'd0}); exp_rises += 8;
    end
    for (int i = 0; i < nad; i++) begin
      v = (i == nad - 1 && nad > 2) ? 8'hFF : seed ^ 8'(8'h5A + i * 37);
      hdr.push_back(v); exp_tx.push_back('{v, 3'(hw), 2'd1}); exp_rises += 8 / hw;
    end
    if (!nd && ndat > 0) begin
      for (int i = 0; i < ndat; i++) begin
        v = 8'(seed * 3 + i * 29 + 8'h81);
        if (rd) begin
          rd_src.push_back(v); exp_rx.push_back(v);
        end else begin
          hdr.push_back(v); exp_tx.push_back('{v, 3'(lanes), 2'd2});
        end
        exp_rises += 8 / lanes;
      end
    end
    rd_w = lanes; rd_bit = 0; rx_stall = rxst;
    cfg_cmd_len = 4'(ncmd); cfg_ad_len = 4'(nad); cfg_lane_mode = 2'(lm);
    cfg_xmode = xm; cfg_nodata = nd; cfg_read = rd; cfg_data_len = LEN_W'(ndat);
    snap0 = sck_rises;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    chk(cs_n == 1'b0 && busy, "R10 cs_n low after start", int'(cs_n), 0);
    foreach (hdr[k]) begin
      if (txst) begin
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        snap = sck_rises;
        repeat (4) @(negedge clk);
        chk(sck_rises == snap && tx_ready && !sck, "R8 bus holds without tx byte", sck_rises, snap);
      end
      @(posedge clk); #1;
      tx_valid = 1'b1; tx_data = hdr[k];
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      @(posedge clk); #1;
      tx_valid = 1'b0;
    end
    t = 0;
    @(negedge clk);
    while (!done && t < 4000) begin
      @(negedge clk); t++;
    end
    chk(done == 1'b1, "R9 done pulse seen", int'(done), 1);
    chk(cs_n == 1'b0, "R9 cs_n still low with done", int'(cs_n), 0);
    @(negedge clk);
    chk(cs_n && !done && !busy, "R9 cs_n released after done", int'({cs_n, done, busy}), 4);
    repeat (24) @(negedge clk);
    chk(exp_tx.size() == 0, "R7 all outbound bytes sent, none extra", exp_tx.size(), 0);
    chk(exp_rx.size() == 0, "R6 all inbound bytes delivered", exp_rx.size(), 0);
    chk(sck_rises - snap0 == exp_rises, "R4 SCK period count", sck_rises - snap0, exp_rises);
    exp_tx.delete(); exp_rx.delete(); rd_src.delete();
    rx_stall = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin
    #1_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sck && io_oe == 4'b0000 && !done && !tx_ready && !rx_valid,
        "R1 reset state", int'({cs_n, sck, io_oe, done, tx_ready, rx_valid}), 9'h100);
    // single lane write (R2 R3 R5)
    run_op(1, 3, 0, 1'b0, 1'b0, 1'b0, 4, 8'h9F, 1'b0, 1'b0);
    // dual read, addr/dummy on one lane (R3 R6)
    run_op(1, 4, 1, 1'b1, 1'b0, 1'b1, 4, 8'h3B, 1'b0, 1'b0);
    // quad read, addr on four lanes, consumer stalls (R4 R6 R8)
    run_op(1, 3, 2, 1'b0, 1'b0, 1'b1, 5, 8'hEB, 1'b0, 1'b1);
    // quad write with cross-mode, producer stalls (R3 R5 R8)
    run_op(1, 2, 2, 1'b1, 1'b0, 1'b0, 3, 8'h32, 1'b1, 1'b0);
    // no-data flag with nonzero count (R7)
    run_op(1, 2, 2, 1'b0, 1'b1, 1'b0, 5, 8'h20, 1'b0, 1'b0);
    // zero data count, read direction (R7)
    run_op(1, 3, 1, 1'b0, 1'b0, 1'b1, 0, 8'h05, 1'b0, 1'b0);
    // lane mode 3 decodes as quad (R4)
    run_op(1, 1, 3, 1'b0, 1'b0, 1'b1, 2, 8'h6B, 1'b0, 1'b0);
    // dual write, address on two lanes (R4 R5)
    run_op(1, 3, 1, 1'b0, 1'b0, 1'b0, 3, 8'hA2, 1'b0, 1'b0);
    // single lane read sampled on IO1 (R6)
    run_op(1, 3, 0, 1'b0, 1'b0, 1'b1, 3, 8'h03, 1'b0, 1'b1);
    summary();
    $finish;
  end
endmodule